// File: doc/BRIEF.md
# Pipeline Hazard and Branch Controller

This block is the control core of a four-stage in-order pipeline (fetch, decode, execute, write-back). It owns the program counter and one valid bit per stage. Every cycle it decides whether the stages advance, hold or are cleared. The datapath around it reports the register fields of the instructions sitting in decode, execute and write-back, plus the outcome of any branch or jump in execute. In return the controller drives the stage hold enables, bubble insertion, fetch-slot and decode-slot invalidation, a PC redirect with its target, and the operand source selects for the ALU.

Conditional branches are predicted not taken, so fetch always continues sequentially. A branch that execute finds taken redirects fetch and clears both younger stages. An unconditional jump is treated more cheaply. While the jump sits in decode, fetch is held and the jump moves on alone. When execute resolves the jump, only the one fetched instruction behind it is invalidated. Read-after-write dependencies are resolved either by forwarding results to the ALU operands or, when forwarding is configured off, by interlocking decode until the producer has retired.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While `rst` is high, every stage valid bit is 0 and `pc` equals `RESET_VEC`. The first fetch after reset uses `RESET_VEC`. `stage_vld` bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 write-back.
- R2: With no hazard, jump or redirect, `pc` advances by 4 after each valid fetch, and valid bits shift one stage per cycle, so the pipe is full four cycles after reset is released.
- R3: A valid taken conditional branch in execute asserts `redirect`, `kill_f` and `kill_d` in the same cycle, with `redirect_pc` equal to `e_target`. In the next cycle `pc` equals the target, decode and execute are invalid, and write-back holds the branch.
- R4: A valid conditional branch in execute that is not taken causes no redirect and no kill, and fetch stays sequential.
- R5: A valid unconditional jump in decode raises `stall_f` without `stall_d`. In the next cycle `pc` is unchanged, decode is invalid, and the jump is valid in execute.
- R6: A valid jump in execute asserts `redirect` and `kill_f` with `redirect_pc` equal to `e_target`, but not `kill_d`.
- R7: With forwarding disabled, a decode source register that matches the destination of a valid writing instruction in execute or write-back raises `stall_f`, `stall_d` and `bubble_e` until the producer has left write-back.
- R8: With forwarding enabled, the operand source codes `fwd_a`/`fwd_b` are 0 for register file, 1 for execute result and 2 for write-back result. Execute takes priority over write-back, and the two operands are selected independently. The codes are registered and apply to the instruction now in execute.
- R9: Register x0 never causes a stall and never selects a forwarded source.
- R10: With forwarding enabled, a dependency on an execute-stage producer whose result is flagged late (`e_late`) causes the same stall as in R7.
- R11: When a redirect and a stall condition occur in the same cycle, the redirect wins and `stall_f`, `stall_d` and `bubble_e` stay low.
- R12: During a data stall, `pc` and the fetch and decode valid bits hold, and execute becomes invalid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_rs1 | input | 5 | Decode source register A |
| d_rs2 | input | 5 | Decode source register B |
| d_use_rs1 | input | 1 | Decode instruction reads source A |
| d_use_rs2 | input | 1 | Decode instruction reads source B |
| d_jump | input | 1 | Decode instruction is an unconditional jump |
| e_rd | input | 5 | Execute destination register |
| e_we | input | 1 | Execute instruction writes a register |
| e_late | input | 1 | Execute result not available for forwarding this cycle |
| e_branch | input | 1 | Execute instruction is a conditional branch |
| e_taken | input | 1 | Execute branch outcome is taken |
| e_jump | input | 1 | Execute instruction is an unconditional jump |
| e_target | input | 32 | Resolved target in execute |
| w_rd | input | 5 | Write-back destination register |
| w_we | input | 1 | Write-back instruction writes a register |
| pc | output | 32 | Address fetched this cycle |
| stage_vld | output | 4 | Valid bits: fetch, decode, execute, write-back (bit 0 to 3) |
| stall_f | output | 1 | Hold the fetch stage |
| stall_d | output | 1 | Hold the decode stage |
| bubble_e | output | 1 | Insert a bubble into execute |
| kill_f | output | 1 | Invalidate the fetched instruction |
| kill_d | output | 1 | Invalidate the decode instruction |
| redirect | output | 1 | Load the PC with redirect_pc |
| redirect_pc | output | 32 | Redirect target |
| fwd_a | output | 2 | Operand A source for the instruction in execute |
| fwd_b | output | 2 | Operand B source for the instruction in execute |

## Verification
The assertions assume that the datapath presents the register and branch fields of whichever instruction the controller currently shows valid in each stage. Fields given for an invalid stage are masked inside the block and do not matter. They also assume that `d_jump` stays high only while the jump really sits in decode, and that `e_jump` is raised in the cycle after the jump has left decode. The bench keeps to this by tracking stage occupancy by hand in every scenario. Each cycle it drives the fields that belong to the instruction each stage holds, and it clears them once that instruction has moved on.

// File: rtl/phc_pkg.sv
package phc_pkg;

    typedef enum logic [1:0] {
        SRC_RF = 2'd0,
        SRC_EX = 2'd1,
        SRC_WB = 2'd2
    } opnd_src_e;

    typedef struct packed {
        logic w;
        logic e;
        logic d;
        logic f;
    } stage_vld_t;

    function automatic opnd_src_e pick_src(input logic hit_ex, input logic hit_wb);
        if (hit_ex)      return SRC_EX;
        else if (hit_wb) return SRC_WB;
        else             return SRC_RF;
    endfunction

endpackage

// File: rtl/phc_hazard_unit.sv
module phc_hazard_unit
    import phc_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter bit FWD_EN = 1'b1
) (
    input  logic              d_valid,
    input  logic [2*REG_W-1:0] d_rs,
    input  logic [1:0]        d_use,
    input  logic              e_valid,
    input  logic [REG_W-1:0]  e_rd,
    input  logic              e_we,
    input  logic              e_late,
    input  logic              w_valid,
    input  logic [REG_W-1:0]  w_rd,
    input  logic              w_we,
    output logic              raw_stall,
    output opnd_src_e         src_a,
    output opnd_src_e         src_b
);
    localparam int NUM_OPND = 2;

    logic [NUM_OPND-1:0] hit_ex;
    logic [NUM_OPND-1:0] hit_wb;
    logic                prod_ex;
    logic                prod_wb;

    assign prod_ex = e_valid && e_we && (e_rd != '0);
    assign prod_wb = w_valid && w_we && (w_rd != '0);

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        logic [REG_W-1:0] rs;
        logic             reads;
        assign rs     = d_rs[g*REG_W +: REG_W];
        assign reads  = d_use[g] && (rs != '0);
        assign hit_ex[g] = reads && prod_ex && (rs == e_rd);
        assign hit_wb[g] = reads && prod_wb && (rs == w_rd);
    end

    if (FWD_EN) begin : g_fwd
        assign raw_stall = d_valid && e_late && (|hit_ex);
        assign src_a     = pick_src(hit_ex[0], hit_wb[0]);
        assign src_b     = pick_src(hit_ex[1], hit_wb[1]);
    end else begin : g_interlock
        logic unused_late;
        assign unused_late = e_late;
        assign raw_stall = d_valid && (|(hit_ex | hit_wb));
        assign src_a     = SRC_RF;
        assign src_b     = SRC_RF;
    end

endmodule

// File: rtl/phc_redirect_unit.sv
module phc_redirect_unit #(
    parameter int XLEN = 32
) (
    input  logic            e_valid,
    input  logic            e_branch,
    input  logic            e_taken,
    input  logic            e_jump,
    input  logic [XLEN-1:0] e_target,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic            kill_f,
    output logic            kill_d
);
    logic br_miss;
    logic jmp_go;

    assign br_miss     = e_valid && e_branch && e_taken;
    assign jmp_go      = e_valid && e_jump;
    assign redirect    = br_miss || jmp_go;
    assign redirect_pc = e_target;
    assign kill_f      = redirect;
    // a jump already left a bubble behind it in decode
    assign kill_d      = br_miss && !jmp_go;

endmodule

// File: rtl/phc_stage_tracker.sv
module phc_stage_tracker
    import phc_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] RESET_VEC   = '0,
    parameter int              INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            redirect,
    input  logic [XLEN-1:0] redirect_pc,
    input  logic            raw_hold,
    input  logic            jump_hold,
    input  opnd_src_e       src_a_in,
    input  opnd_src_e       src_b_in,
    output logic [XLEN-1:0] pc_q,
    output stage_vld_t      vld_q,
    output opnd_src_e       src_a_q,
    output opnd_src_e       src_b_q
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RESET_VEC;
            vld_q   <= '0;
            src_a_q <= SRC_RF;
            src_b_q <= SRC_RF;
        end else if (redirect) begin
            pc_q    <= redirect_pc;
            vld_q.f <= 1'b1;
            vld_q.d <= 1'b0;
            vld_q.e <= 1'b0;
            vld_q.w <= vld_q.e;
            src_a_q <= SRC_RF;
            src_b_q <= SRC_RF;
        end else if (raw_hold) begin
            vld_q.e <= 1'b0;
            vld_q.w <= vld_q.e;
            src_a_q <= SRC_RF;
            src_b_q <= SRC_RF;
        end else if (jump_hold) begin
            vld_q.d <= 1'b0;
            vld_q.e <= vld_q.d;
            vld_q.w <= vld_q.e;
            src_a_q <= src_a_in;
            src_b_q <= src_b_in;
        end else begin
            if (vld_q.f) pc_q <= pc_q + STEP;
            vld_q.f <= 1'b1;
            vld_q.d <= vld_q.f;
            vld_q.e <= vld_q.d;
            vld_q.w <= vld_q.e;
            src_a_q <= vld_q.d ? src_a_in : SRC_RF;
            src_b_q <= vld_q.d ? src_b_in : SRC_RF;
        end
    end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import phc_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              REG_W       = 5,
    parameter logic [XLEN-1:0] RESET_VEC   = 32'h0000_1000,
    parameter int              INSTR_BYTES = 4,
    parameter bit              FWD_EN      = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] d_rs1,
    input  logic [REG_W-1:0] d_rs2,
    input  logic             d_use_rs1,
    input  logic             d_use_rs2,
    input  logic             d_jump,
    input  logic [REG_W-1:0] e_rd,
    input  logic             e_we,
    input  logic             e_late,
    input  logic             e_branch,
    input  logic             e_taken,
    input  logic             e_jump,
    input  logic [XLEN-1:0]  e_target,
    input  logic [REG_W-1:0] w_rd,
    input  logic             w_we,
    output logic [XLEN-1:0]  pc,
    output logic [3:0]       stage_vld,
    output logic             stall_f,
    output logic             stall_d,
    output logic             bubble_e,
    output logic             kill_f,
    output logic             kill_d,
    output logic             redirect,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b
);
    stage_vld_t vld;
    opnd_src_e  src_a_n, src_b_n, src_a_q, src_b_q;
    logic       raw_req;
    logic       raw_hold;
    logic       jump_hold;

    phc_hazard_unit #(
        .REG_W (REG_W),
        .FWD_EN(FWD_EN)
    ) u_hazard (
        .d_valid  (vld.d),
        .d_rs     ({d_rs2, d_rs1}),
        .d_use    ({d_use_rs2, d_use_rs1}),
        .e_valid  (vld.e),
        .e_rd     (e_rd),
        .e_we     (e_we),
        .e_late   (e_late),
        .w_valid  (vld.w),
        .w_rd     (w_rd),
        .w_we     (w_we),
        .raw_stall(raw_req),
        .src_a    (src_a_n),
        .src_b    (src_b_n)
    );

    phc_redirect_unit #(
        .XLEN(XLEN)
    ) u_redirect (
        .e_valid    (vld.e),
        .e_branch   (e_branch),
        .e_taken    (e_taken),
        .e_jump     (e_jump),
        .e_target   (e_target),
        .redirect   (redirect),
        .redirect_pc(redirect_pc),
        .kill_f     (kill_f),
        .kill_d     (kill_d)
    );

    // redirect beats any hold; a data hold beats the jump hold
    assign raw_hold  = raw_req && !redirect;
    assign jump_hold = vld.d && d_jump && !redirect && !raw_hold;

    phc_stage_tracker #(
        .XLEN       (XLEN),
        .RESET_VEC  (RESET_VEC),
        .INSTR_BYTES(INSTR_BYTES)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .redirect   (redirect),
        .redirect_pc(redirect_pc),
        .raw_hold   (raw_hold),
        .jump_hold  (jump_hold),
        .src_a_in   (src_a_n),
        .src_b_in   (src_b_n),
        .pc_q       (pc),
        .vld_q      (vld),
        .src_a_q    (src_a_q),
        .src_b_q    (src_b_q)
    );

    assign stage_vld = vld;
    assign stall_f   = raw_hold || jump_hold;
    assign stall_d   = raw_hold;
    assign bubble_e  = raw_hold;
    assign fwd_a     = src_a_q;
    assign fwd_b     = src_b_q;

endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            d_jump,
    input logic [XLEN-1:0] pc,
    input logic [3:0]      stage_vld,
    input logic            stall_f,
    input logic            stall_d,
    input logic            bubble_e,
    input logic            redirect,
    input logic [XLEN-1:0] redirect_pc,
    input logic [1:0]      fwd_a,
    input logic [1:0]      fwd_b
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (stage_vld == 4'b0000 && pc == RESET_VEC));

    // R3
    a_r3_redirect_clears: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (stage_vld[1] == 1'b0 && stage_vld[2] == 1'b0 && pc == $past(redirect_pc)));

    // R5
    a_r5_jump_holds_fetch: assert property (@(posedge clk) disable iff (rst)
        (stage_vld[1] && d_jump && !redirect && !stall_d) |=> (stage_vld[1] == 1'b0 && $stable(pc)));

    // R11
    a_r11_redirect_wins: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (!stall_f && !stall_d && !bubble_e));

    // R12
    a_r12_stall_freezes: assert property (@(posedge clk) disable iff (rst)
        stall_d |=> ($stable(pc) && stage_vld[2] == 1'b0 && stage_vld[1] == 1'b1));

    // R8
    a_r8_src_code_legal: assert property (@(posedge clk) disable iff (rst)
        (fwd_a != 2'b11 && fwd_b != 2'b11));

endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(
    .XLEN     (XLEN),
    .RESET_VEC(RESET_VEC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .d_jump     (d_jump),
    .pc         (pc),
    .stage_vld  (stage_vld),
    .stall_f    (stall_f),
    .stall_d    (stall_d),
    .bubble_e   (bubble_e),
    .redirect   (redirect),
    .redirect_pc(redirect_pc),
    .fwd_a      (fwd_a),
    .fwd_b      (fwd_b)
);

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  d_rs1 = '0, d_rs2 = '0, e_rd = '0, w_rd = '0;
    logic        d_use_rs1 = 0, d_use_rs2 = 0, d_jump = 0;
    logic        e_we = 0, e_late = 0, e_branch = 0, e_taken = 0, e_jump = 0, w_we = 0;
    logic [31:0] e_target = '0;

    logic [31:0] pc, rpc, pc_n, rpc_n;
    logic [3:0]  vld, vld_n;
    logic        sf, sd, be, kf, kd, rd_o;
    logic        sf_n, sd_n, be_n, kf_n, kd_n, rd_n;
    logic [1:0]  fa, fb, fa_n, fb_n;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pipe_hazard_ctrl #(.RESET_VEC(RV), .FWD_EN(1'b1)) u_pipe_hazard_ctrl (
        .clk(clk), .rst(rst), .d_rs1(d_rs1), .d_rs2(d_rs2), .d_use_rs1(d_use_rs1),
        .d_use_rs2(d_use_rs2), .d_jump(d_jump), .e_rd(e_rd), .e_we(e_we), .e_late(e_late),
        .e_branch(e_branch), .e_taken(e_taken), .e_jump(e_jump), .e_target(e_target),
        .w_rd(w_rd), .w_we(w_we), .pc(pc), .stage_vld(vld), .stall_f(sf), .stall_d(sd),
        .bubble_e(be), .kill_f(kf), .kill_d(kd), .redirect(rd_o), .redirect_pc(rpc),
        .fwd_a(fa), .fwd_b(fb));

    pipe_hazard_ctrl #(.RESET_VEC(RV), .FWD_EN(1'b0)) u_pipe_hazard_ctrl_nf (
        .clk(clk), .rst(rst), .d_rs1(d_rs1), .d_rs2(d_rs2), .d_use_rs1(d_use_rs1),
        .d_use_rs2(d_use_rs2), .d_jump(d_jump), .e_rd(e_rd), .e_we(e_we), .e_late(e_late),
        .e_branch(e_branch), .e_taken(e_taken), .e_jump(e_jump), .e_target(e_target),
        .w_rd(w_rd), .w_we(w_we), .pc(pc_n), .stage_vld(vld_n), .stall_f(sf_n), .stall_d(sd_n),
        .bubble_e(be_n), .kill_f(kf_n), .kill_d(kd_n), .redirect(rd_n), .redirect_pc(rpc_n),
        .fwd_a(fa_n), .fwd_b(fb_n));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic clear_in();
        d_rs1 = 0; d_rs2 = 0; d_use_rs1 = 0; d_use_rs2 = 0; d_jump = 0;
        e_rd = 0; e_we = 0; e_late = 0; e_branch = 0; e_taken = 0; e_jump = 0;
        e_target = 0; w_rd = 0; w_we = 0;
    endtask

    // R1 and R2: reset state, then fill the pipe
    task automatic t_reset_fill();
        clear_in();
        rst = 1'b1;
        repeat (3) cyc();
        chk("R1 reset valid", 32'(vld), 32'h0);
        chk("R1 reset pc", pc, RV);
        rst = 1'b0;
        cyc();
        chk("R1 first fetch pc", pc, RV);
        chk("R2 fill vld 1", 32'(vld), 32'h1);
        cyc();
        chk("R2 pc step", pc, RV + 4);
        chk("R2 fill vld 2", 32'(vld), 32'h3);
        cyc();
        cyc();
        chk("R2 pc after fill", pc, RV + 12);
        chk("R2 full pipe", 32'(vld), 32'hF);
    endtask

    // R8 and R9: forwarding selects
    task automatic t_forward();
        t_reset_fill();
        d_use_rs1 = 1; d_rs1 = 5; d_use_rs2 = 1; d_rs2 = 7;
        e_we = 1; e_rd = 5; w_we = 1; w_rd = 7;
        #1 chk("R8 no stall when forwarding", 32'(sf), 32'h0);
        cyc();
        chk("R8 fwd_a from execute", 32'(fa), 32'h1);
        chk("R8 fwd_b from write-back", 32'(fb), 32'h2);
        d_rs2 = 9; w_rd = 5;
        cyc();
        chk("R8 execute beats write-back", 32'(fa), 32'h1);
        chk("R8 operand b from regfile", 32'(fb), 32'h0);
        d_rs1 = 0; d_rs2 = 0; e_rd = 0; w_rd = 0;
        cyc();
        chk("R9 x0 not forwarded a", 32'(fa), 32'h0);
        chk("R9 x0 not forwarded b", 32'(fb), 32'h0);
        clear_in();
    endtask

    // R9, R7 and R12 on the interlocking instance
    task automatic t_interlock();
        logic [31:0] p;
        t_reset_fill();
        d_use_rs1 = 1; d_rs1 = 0; e_we = 1; e_rd = 0;
        #1 chk("R9 x0 no interlock", 32'(sf_n), 32'h0);
        cyc();
        d_rs1 = 6; e_rd = 6;
        #1;
        chk("R7 stall_f", 32'(sf_n), 32'h1);
        chk("R7 stall_d", 32'(sd_n), 32'h1);
        chk("R7 bubble_e", 32'(be_n), 32'h1);
        chk("R8 forwarding instance does not stall", 32'(sf), 32'h0);
        p = pc_n;
        cyc();
        chk("R12 pc held", pc_n, p);
        chk("R12 vld after stall", 32'(vld_n), 32'hB);
        e_we = 0; w_we = 1; w_rd = 6;
        #1 chk("R7 stall on write-back producer", 32'(sd_n), 32'h1);
        cyc();
        w_we = 0;
        #1 chk("R7 stall released", 32'(sd_n), 32'h0);
        cyc();
        chk("R7 pc resumes", pc_n, p + 4);
        clear_in();
    endtask

    // R10: late execute result
    task automatic t_late();
        t_reset_fill();
        d_use_rs1 = 1; d_rs1 = 6; e_we = 1; e_rd = 6; e_late = 1;
        #1;
        chk("R10 late stall_f", 32'(sf), 32'h1);
        chk("R10 late bubble_e", 32'(be), 32'h1);
        d_rs1 = 3;
        #1 chk("R10 no stall without match", 32'(sf), 32'h0);
        clear_in();
    endtask

    // R3, R11, R4: conditional branches
    task automatic t_branch();
        logic [31:0] p;
        t_reset_fill();
        p = pc;
        e_branch = 1; e_taken = 0; e_target = 32'h0000_2000;
        #1;
        chk("R4 no redirect", 32'(rd_o), 32'h0);
        chk("R4 no kill", 32'({kf, kd}), 32'h0);
        cyc();
        chk("R4 sequential pc", pc, p + 4);
        e_taken = 1;
        d_use_rs1 = 1; d_rs1 = 6; e_we = 1; e_rd = 6; e_late = 1;
        #1;
        chk("R3 redirect", 32'(rd_o), 32'h1);
        chk("R3 redirect_pc", rpc, 32'h0000_2000);
        chk("R3 kills", 32'({kf, kd}), 32'h3);
        chk("R11 redirect beats stall", 32'({sf, sd, be}), 32'h0);
        cyc();
        clear_in();
        chk("R3 pc at target", pc, 32'h0000_2000);
        chk("R3 vld after flush", 32'(vld), 32'h9);
        cyc();
        chk("R3 fetch continues", pc, 32'h0000_2004);
    endtask

    // R5, R6: unconditional jump
    task automatic t_jump();
        logic [31:0] p;
        t_reset_fill();
        p = pc;
        d_jump = 1;
        #1;
        chk("R5 stall_f", 32'(sf), 32'h1);
        chk("R5 no stall_d", 32'(sd), 32'h0);
        cyc();
        d_jump = 0;
        chk("R5 pc held", pc, p);
        chk("R5 vld during jump", 32'(vld), 32'hD);
        e_jump = 1; e_target = 32'h0000_3000;
        #1;
        chk("R6 redirect", 32'(rd_o), 32'h1);
        chk("R6 redirect_pc", rpc, 32'h0000_3000);
        chk("R6 kill_f only", 32'({kf, kd}), 32'h2);
        cyc();
        clear_in();
        chk("R6 pc at target", pc, 32'h0000_3000);
        chk("R6 vld after jump", 32'(vld), 32'h9);
    endtask

    initial begin
        fork
            begin
                t_forward();
                t_interlock();
                t_late();
                t_branch();
                t_jump();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule